// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words presented with the write enable low are stored on write-clock edges. Words leave on read-clock edges. Pointers cross between the two domains as Gray codes through two-flop synchronizers. The block reports a full/ready status, an empty/ready status, a half-full flag, and almost-empty and almost-full flags. The two offsets for the almost flags are parameters. All flags and enables are active low.

Two behaviours are captured only while the master reset input is low. The first is the read timing. In standard timing, a word is moved to the output register only by a read. In first-word fall-through timing, the head word is presented on its own and a read advances past it. The second is the timing of the almost flags. They are either decoded combinationally from the raw pointers of both domains, or registered in the domain that owns each flag. A partial reset empties the buffer and keeps both captured choices.

"Stored words" below means the words held in the storage array. In fall-through timing, the word already presented on `dout` is not counted, so the block holds up to DEPTH+1 words in that mode.

Top module: `dualclk_flag_fifo`

## Requirements
- R1: `ft_sel` and `sflag_sel` are captured on clock edges while `mrst_n` is low; changing them after `mrst_n` rises has no effect until the next master reset.
- R2: With `sflag_sel` low at master reset, `ae_n` and `af_n` follow the pointers combinationally right after the clock edge that moves either pointer. With it high, `ae_n` is registered in the read domain and `af_n` in the write domain, so a move by the opposite side reaches them only after synchronization.
- R3: After master reset: `ae_n`=0, `af_n`=1, `half_n`=1 and `dout`=0. In standard timing `rflag_n`=0 (empty) and `wflag_n`=1. In fall-through timing `rflag_n`=1 (nothing presented) and `wflag_n`=0 (ready).
- R4: A partial reset (`prst_n` low) discards all words and gives the same flag and `dout` values as R3 for the timing mode already captured.
- R5: In standard timing, a read-clock edge with `rd_en_n` low while not empty loads the next word into `dout`; with `rd_en_n` high, `dout` holds.
- R6: In fall-through timing, the first word written into an empty buffer appears on `dout` with `rflag_n` low without any read. A read-clock edge with `rd_en_n` low while `rflag_n` is low consumes that word.
- R7: Words leave in the order they were accepted, under any mix of concurrent writes and reads, in both timing modes.
- R8: Once the pointers have settled, `half_n` is low exactly when more than DEPTH/2 words are stored.
- R9: Once settled, `af_n` is low exactly when at least DEPTH-AF_OFS words are stored, and `ae_n` is low exactly when at most AE_OFS words are stored.
- R10: Standard timing: `wflag_n` is low exactly when DEPTH words are stored, and `rflag_n` is high exactly when at least one word is stored. Fall-through timing: `wflag_n` is high exactly when DEPTH words are stored, and `rflag_n` is low exactly when a word is presented.
- R11: A write while full and a read while empty are ignored and leave the pointers and the stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks |
| ft_sel | input | 1 | Read timing choice captured during master reset (1 = fall-through) |
| sflag_sel | input | 1 | Almost-flag timing captured during master reset (1 = registered) |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| dout | output | DW | Output register |
| rflag_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| wflag_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| half_n | output | 1 | Half-full, active low |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
The bench builds the block with DW=8, AW=3 (eight locations), AE_OFS=2 and AF_OFS=2. With only eight locations, every occupancy level from empty to full can be stepped through in both timing modes. Every almost-flag and half-full threshold is crossed within a few writes, and overflow and underflow attempts are cheap. The bench runs all four combinations of captured modes. The write and read clocks are unrelated. This lets the combinational-versus-registered almost-flag timing show up as a flag change seen half a clock after the opposite side moves its pointer.

// File: rtl/dualclk_flag_fifo.sv
module dualclk_flag_fifo #(
  parameter int DW     = 18,
  parameter int AW     = 4,
  parameter int AE_OFS = 3,
  parameter int AF_OFS = 3
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          ft_sel,
  input  logic          sflag_sel,
  input  logic          wr_en_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  output logic [DW-1:0] dout,
  output logic          rflag_n,
  output logic          wflag_n,
  output logic          half_n,
  output logic          ae_n,
  output logic          af_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [AW:0] HALF_LVL = PW'(DEPTH / 2);
  localparam logic [AW:0] AF_LVL   = PW'(DEPTH - AF_OFS);
  localparam logic [AW:0] AE_LVL   = PW'(AE_OFS);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  wire wrst = !mrst_n || !prst_n;
  wire rrst = !mrst_n || !prst_n;

  // write domain
  logic        ft_w, sf_w, full, half_q, afs_q;
  logic [AW:0] wbin, wgray, rg_s1, rg_s2;
  logic [AW:0] rbin, rgray;

  wire         wr_ok    = !wr_en_n && !full;
  wire [AW:0]  wbin_nx  = wbin + PW'(wr_ok);
  wire [AW:0]  wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  wire [AW:0]  wcnt_nx  = wbin_nx - g2b(rg_s2);

  always_ff @(posedge wr_clk) begin
    if (!mrst_n) begin
      ft_w <= ft_sel;
      sf_w <= sflag_sel;
    end
    if (wrst) begin
      wbin   <= '0;
      wgray  <= '0;
      rg_s1  <= '0;
      rg_s2  <= '0;
      full   <= 1'b0;
      half_q <= 1'b1;
      afs_q  <= 1'b1;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      rg_s1  <= rgray;
      rg_s2  <= rg_s1;
      full   <= (wgray_nx == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
      half_q <= !(wcnt_nx > HALF_LVL);
      afs_q  <= !(wcnt_nx >= AF_LVL);
    end
  end

  always_ff @(posedge wr_clk)
    if (wr_ok && !wrst) mem[wbin[AW-1:0]] <= din;

  // read domain
  logic          ft_r, sf_r, emp, ov, aes_q;
  logic [AW:0]   wg_s1, wg_s2;
  logic [DW-1:0] dq;

  wire         pop      = !emp && (ft_r ? (!ov || !rd_en_n) : !rd_en_n);
  wire [AW:0]  rbin_nx  = rbin + PW'(pop);
  wire [AW:0]  rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
  wire [AW:0]  rcnt_nx  = g2b(wg_s2) - rbin_nx;

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) begin
      ft_r <= ft_sel;
      sf_r <= sflag_sel;
    end
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      emp   <= 1'b1;
      ov    <= 1'b0;
      aes_q <= 1'b0;
      dq    <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      emp   <= (rgray_nx == wg_s2);
      aes_q <= !(rcnt_nx <= AE_LVL);
      ov    <= ft_r & (pop | (ov & rd_en_n));
      if (pop) dq <= mem[rbin[AW-1:0]];
    end
  end

  // combinational almost flags straight from both pointers
  wire [AW:0] raw_cnt = wbin - rbin;
  wire        ae_a    = !(raw_cnt <= AE_LVL);
  wire        af_a    = !(raw_cnt >= AF_LVL);

  assign dout    = dq;
  assign rflag_n = ft_r ? !ov : !emp;
  assign wflag_n = ft_w ? full : !full;
  assign half_n  = half_q;
  assign ae_n    = sf_r ? aes_q : ae_a;
  assign af_n    = sf_w ? afs_q : af_a;

  // R11
  wr_full_ignored_chk: assert property (@(posedge wr_clk) disable iff (wrst)
    (full && !wr_en_n) |=> (wbin == $past(wbin)));
  // R11
  rd_empty_ignored_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    emp |=> (rbin == $past(rbin)));
  // R5
  std_hold_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    (!ft_r && rd_en_n) |=> $stable(dq));
  // R6
  fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    (ft_r && ov && rd_en_n) |=> (ov && $stable(dq)));
  // R7
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R7
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R1
  mode_hold_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    $stable(ft_r) && $stable(sf_r));
endmodule

// File: tb/dualclk_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module dualclk_flag_fifo_tb_top;
  localparam int DW = 8, AW = 3, DEPTH = 8, AEO = 2, AFO = 2;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, ft_sel = 0, sflag_sel = 0;
  logic wr_en_n = 1, rd_en_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic rflag_n, wflag_n, half_n, ae_n, af_n;

  dualclk_flag_fifo #(.DW(DW), .AW(AW), .AE_OFS(AEO), .AF_OFS(AFO)) dut_i (
    .wr_clk(wclk), .rd_clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .ft_sel(ft_sel), .sflag_sel(sflag_sel), .wr_en_n(wr_en_n), .din(din),
    .rd_en_n(rd_en_n), .dout(dout), .rflag_n(rflag_n), .wflag_n(wflag_n),
    .half_n(half_n), .ae_n(ae_n), .af_n(af_n));

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0, ft = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_dout = '0;
  logic [DW-1:0] seq = 8'h01;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ram_cnt();
    if (ft) return (q.size() > 0) ? q.size() - 1 : 0;
    return q.size();
  endfunction

  task automatic write_cycle(input bit en, input logic [DW-1:0] v);
    @(negedge wclk);
    wr_en_n = !en;
    din = v;
    if (en && (ft ? (wflag_n == 1'b0) : (wflag_n == 1'b1))) q.push_back(v);
  endtask

  task automatic read_cycle(input bit en);
    @(negedge rclk);
    if (!ft) begin
      chk("R5 standard output register", 64'(dout), 64'(exp_dout));
      if (rflag_n) chk("R10 not-empty backed by data", 64'(q.size() > 0), 64'd1);
      rd_en_n = !en;
      if (en && rflag_n && q.size() > 0) exp_dout = q.pop_front();
    end else begin
      if (!rflag_n) begin
        chk("R6 ready backed by data", 64'(q.size() > 0), 64'd1);
        if (q.size() > 0) chk("R7 fall-through head word", 64'(dout), 64'(q[0]));
      end
      rd_en_n = !en;
      if (en && !rflag_n && q.size() > 0) void'(q.pop_front());
    end
  endtask

  task automatic settle();
    fork
      repeat (14) write_cycle(0, '0);
      repeat (10) read_cycle(0);
    join
  endtask

  task automatic write_one();
    write_cycle(1, seq);
    seq = seq + 1;
  endtask

  task automatic read_one();
    read_cycle(1);
    read_cycle(0);
  endtask

  task automatic check_flags(input string ctx);
    int n;
    n = ram_cnt();
    if (!ft) begin
      chk({"R10 empty flag ", ctx}, 64'(rflag_n), 64'(n > 0));
      chk({"R10 full flag ", ctx}, 64'(wflag_n), 64'(n != DEPTH));
    end else begin
      chk({"R10 output-ready ", ctx}, 64'(rflag_n), 64'(q.size() == 0));
      chk({"R10 input-ready ", ctx}, 64'(wflag_n), 64'(n == DEPTH));
    end
    chk({"R8 half ", ctx}, 64'(half_n), 64'(!(n > DEPTH / 2)));
    chk({"R9 almost-empty ", ctx}, 64'(ae_n), 64'(!(n <= AEO)));
    chk({"R9 almost-full ", ctx}, 64'(af_n), 64'(!(n >= DEPTH - AFO)));
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " rflag"}, 64'(rflag_n), 64'(ft));
    chk({tag, " wflag"}, 64'(wflag_n), 64'(!ft));
    chk({tag, " ae"}, 64'(ae_n), 64'd0);
    chk({tag, " af"}, 64'(af_n), 64'd1);
    chk({tag, " half"}, 64'(half_n), 64'd1);
    chk({tag, " dout"}, 64'(dout), 64'd0);
  endtask

  task automatic do_mreset(input bit f, input bit s);
    @(negedge wclk);
    mrst_n = 0; ft_sel = f; sflag_sel = s; wr_en_n = 1; rd_en_n = 1;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    mrst_n = 1;
    q.delete(); exp_dout = '0; ft = f;
  endtask

  task automatic do_preset();
    @(negedge wclk);
    prst_n = 0;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    prst_n = 1;
    q.delete(); exp_dout = '0;
  endtask

  task automatic drain();
    int g;
    g = 0;
    while (q.size() > 0 && g < 600) begin
      read_cycle(1);
      g++;
    end
    read_cycle(0);
    settle();
  endtask

  task automatic session(input bit f, input bit s);
    int cap;
    cap = DEPTH + (f ? 1 : 0);
    do_mreset(f, s);
    check_reset_state("R3");
    ft_sel = !f; sflag_sel = !s;
    settle();
    check_reset_state("R1 late select ignored");
    for (int k = 0; k < cap; k++) begin
      write_one();
      settle();
      check_flags("fill");
      if (f && k == 0) begin
        chk("R6 first word presented without read", 64'(rflag_n), 64'd0);
        chk("R6 first word value", 64'(dout), 64'(q[0]));
      end
    end
    write_one();
    write_one();
    settle();
    check_flags("after overflow");
    for (int k = 0; k < cap; k++) begin
      read_one();
      settle();
      check_flags("drain");
    end
    read_one();
    read_one();
    settle();
    chk("R11 overflow words not stored", 64'(rflag_n), 64'(f ? 1 : 0));
    chk("R11 read while empty keeps dout", 64'(f ? exp_dout : dout), 64'(exp_dout));
    check_flags("after underflow");
    while (ram_cnt() < AEO) begin write_one(); settle(); end
    write_one();
    write_cycle(0, '0);
    chk("R2 almost-empty timing", 64'(ae_n), 64'(s ? 0 : 1));
    settle();
    while (ram_cnt() < DEPTH - AFO) begin write_one(); settle(); end
    read_cycle(1);
    read_cycle(0);
    chk("R2 almost-full timing", 64'(af_n), 64'(s ? 0 : 1));
    settle();
    check_flags("after probes");
    do_preset();
    settle();
    check_reset_state("R4");
    repeat (3) begin write_one(); settle(); end
    check_flags("R4 after partial reset refill");
    drain();
    fork
      begin
        repeat (300) begin
          write_cycle($urandom_range(0, 3) != 0, seq);
          seq = seq + 1;
        end
        write_cycle(0, '0);
      end
      begin
        repeat (200) read_cycle($urandom_range(0, 2) != 0);
        read_cycle(0);
      end
    join
    drain();
    check_flags("R7 after streaming");
  endtask

  always @(posedge wclk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      tests++;
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    session(0, 1);
    session(1, 0);
    session(1, 1);
    session(0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule